// File: doc/BRIEF.md
# Quad Low-Side Output Channel Controller

This block holds the control and protection logic for four low-side driver outputs. Each channel is set up by a 2-bit mode command. The command picks one of four behaviours: off with the diagnostic sink current disabled, follow a parallel input pin, forced on, or off with the diagnostic current enabled. The block turns the command into a gate-on signal and a diagnostic-current enable for the analog channel. It also watches three raw comparator inputs per channel: overload, overtemperature and open load.

Overload has to persist through a tick-counted filter before the channel latches off. Overtemperature latches the channel off as soon as it has been synchronized. Either event sets the channel's drive fault flag. Open load is judged only while the driver is off and the sink current is on, and it sets a separate flag once it has been seen for a programmable number of ticks.

A limp-home input hands every output to its parallel pin and ignores the commands. Protection stays active in limp-home, and a fault latched there can only be released by leaving limp-home or by reset. The raw comparator inputs pass through two-flop synchronizers. The filter windows are counted in pulses of an external timebase strobe, so simulation can use short windows.

Top module: `quad_lsd_chan_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, every gate_on, diag_en, flt_ol and flt_d bit reads 0 after that edge.
- R2: With en=1 and limp=0, channel i's command in cmd[2i+1:2i] drives gate_on[i] one clock later: 00 off, 01 equals par_in[i], 10 on, 11 off.
- R3: With en=1 and limp=0, diag_en[i] is 0 for commands 00 and 10. For command 01 it equals the inverse of gate_on[i]. For command 11 it is 1 unless the channel is quiet (R4). diag_en and gate_on are never both 1.
- R4: A channel becomes quiet after reset, after en low with limp=0, and after leaving limp-home. While quiet, command 11 keeps diag_en at 0. Quiet ends when the channel receives any command other than 11 with en=1 and limp=0.
- R5: Overload on a channel whose gate is on sets flt_d and turns the gate off only after OVL_TICKS consecutive tick pulses. A shorter overload pulse leaves flt_d at 0 and the gate on.
- R6: Overtemperature sets flt_d[i] and turns gate_on[i] off within four clocks. Other channels keep their gate state.
- R7: While flt_d[i] is 1, gate_on[i] stays 0 whatever the command or par_in.
- R8: Open load sets flt_ol[i] only while gate_on[i] is 0 and diag_en[i] is 1, after OL_TICKS consecutive ticks. With flt_ol[i] set, the channel can still be turned on.
- R9: Command 00 with en=1 and limp=0 clears that channel's flt_d and flt_ol one clock later. Other channels keep their flags.
- R10: With limp=1, gate_on[i] equals par_in[i] unless flt_d[i] is set, and diag_en[i] is its inverse. Commands and en have no effect in this state.
- R11: In limp-home, overload still latches a channel off. Neither command 00 nor en=0 clears a flt_d set in limp-home. Going from limp=1 to limp=0 clears all flags one clock later.
- R12: With en=0 and limp=0, all gates, diagnostic enables and flags read 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset (supply power-on reset) |
| tick | input | 1 | Timebase strobe for the fault filters |
| en | input | 1 | Global enable; low with limp=0 means all off and all faults cleared |
| limp | input | 1 | Limp-home: outputs follow par_in, commands ignored |
| cmd | input | 2*NCH | Per-channel command, channel i at [2i+1:2i] |
| par_in | input | NCH | Parallel control pins |
| ovl_raw | input | NCH | Raw overload comparator outputs |
| otemp_raw | input | NCH | Raw overtemperature sensor outputs |
| open_raw | input | NCH | Raw open-load comparator outputs |
| gate_on | output | NCH | Driver gate enable per channel |
| diag_en | output | NCH | Diagnostic sink current enable per channel |
| flt_ol | output | NCH | Latched open-load flag per channel |
| flt_d | output | NCH | Latched overload/overtemperature flag per channel |

## Verification
All outputs are registered, so a wrong command decode or a stuck quiet bit shows up on gate_on or diag_en on the clock after the command changes. That is why the random phase checks two clocks after each new command. A filter counter that fails to reset or counts the wrong limit shows as flt_d rising after a short spike, or failing to rise after a long overload, within a few clocks of the programmed window. A wrong clearing path shows as a flag that survives standby, en low or limp exit, or one that vanishes while limp is held. The directed sequence observes each of these at the ports right after the stimulus.

// File: rtl/qc_pkg.sv
// Shared types for the quad output channel controller.
// Assumes a 2-bit command field per channel.
package qc_pkg;
    typedef enum logic [1:0] {
        CMD_STBY = 2'b00,   // off, diagnostics off, clears faults
        CMD_PAR  = 2'b01,   // follow parallel pin
        CMD_ON   = 2'b10,   // forced on
        CMD_OFF  = 2'b11    // off, diagnostics on unless quiet
    } cmd_e;
endpackage

// File: rtl/qc_sync2.sv
// Two-flop synchronizer for a vector of asynchronous comparator bits.
// Assumes each bit is independent (no bus coherency needed).
module qc_sync2 #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages; reset to the inactive level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/qc_persist.sv
// Persistence filter: pulses hit on the LIMIT-th consecutive tick with cond high.
// Assumes LIMIT >= 1; the count restarts whenever cond drops or clr is high.
module qc_persist #(
    parameter int unsigned LIMIT = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic cond,
    output logic hit
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign hit = cond & tick & (cnt == LAST);

    // Count ticks while the condition holds, saturating at the last value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !cond)
            cnt <= '0;
        else if (tick && cnt != LAST)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/qc_chan.sv
// One output channel: command decode, diagnostic-current gating,
// fault latching and clearing, limp-home override.
// Assumes comparator inputs are already synchronized; all outputs registered.
module qc_chan
    import qc_pkg::*;
#(
    parameter int unsigned OVL_TICKS = 15,
    parameter int unsigned OL_TICKS  = 115
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic en,
    input  logic limp,
    input  logic limp_exit,
    input  cmd_e cmd,
    input  logic par,
    input  logic ovl_s,
    input  logic otemp_s,
    input  logic open_s,
    output logic gate_on,
    output logic diag_en,
    output logic flt_ol,
    output logic flt_d
);
    logic active, gclr, clr, ovl_hit, ol_hit;
    logic quiet, quiet_nxt, d_nxt, ol_nxt, want, gate_nxt, diag_nxt;

    assign active = en & ~limp;
    assign gclr   = (~en & ~limp) | limp_exit;
    assign clr    = gclr | (active & (cmd == CMD_STBY));

    qc_persist #(.LIMIT(OVL_TICKS)) ovl_flt_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
        .cond(ovl_s & gate_on), .hit(ovl_hit)
    );

    qc_persist #(.LIMIT(OL_TICKS)) ol_flt_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
        .cond(open_s & ~gate_on & diag_en), .hit(ol_hit)
    );

    // Next-state of the flags, the quiet bit and the drive outputs.
    always_comb begin
        d_nxt     = clr ? 1'b0 : (flt_d | ovl_hit | otemp_s);
        ol_nxt    = clr ? 1'b0 : (flt_ol | ol_hit);
        quiet_nxt = gclr ? 1'b1 : ((active && cmd != CMD_OFF) ? 1'b0 : quiet);
        if (limp)
            want = par;
        else if (active)
            want = (cmd == CMD_ON) | ((cmd == CMD_PAR) & par);
        else
            want = 1'b0;
        gate_nxt = want & ~d_nxt;
        if (limp)
            diag_nxt = ~gate_nxt;
        else if (active && cmd == CMD_PAR)
            diag_nxt = ~gate_nxt;
        else if (active && cmd == CMD_OFF)
            diag_nxt = ~quiet_nxt;
        else
            diag_nxt = 1'b0;
    end

    // State registers; reset leaves the channel off and quiet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_d   <= 1'b0;
            flt_ol  <= 1'b0;
            quiet   <= 1'b1;
            gate_on <= 1'b0;
            diag_en <= 1'b0;
        end else begin
            flt_d   <= d_nxt;
            flt_ol  <= ol_nxt;
            quiet   <= quiet_nxt;
            gate_on <= gate_nxt;
            diag_en <= diag_nxt;
        end
    end
endmodule

// File: rtl/quad_lsd_chan_ctrl.sv
// Top: synchronizes the comparator inputs, detects limp-home exit and
// instantiates NCH channel controllers.
// Assumes en, limp, cmd, par_in and tick are synchronous to clk.
module quad_lsd_chan_ctrl #(
    parameter int unsigned NCH       = 4,
    parameter int unsigned OVL_TICKS = 15,
    parameter int unsigned OL_TICKS  = 115
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             limp,
    input  logic [2*NCH-1:0] cmd,
    input  logic [NCH-1:0]   par_in,
    input  logic [NCH-1:0]   ovl_raw,
    input  logic [NCH-1:0]   otemp_raw,
    input  logic [NCH-1:0]   open_raw,
    output logic [NCH-1:0]   gate_on,
    output logic [NCH-1:0]   diag_en,
    output logic [NCH-1:0]   flt_ol,
    output logic [NCH-1:0]   flt_d
);
    localparam int unsigned SW = 3 * NCH;

    logic [SW-1:0]  raw_s;
    logic [NCH-1:0] ovl_s, otemp_s, open_s;
    logic           limp_q;

    qc_sync2 #(.W(SW)) sync_i (
        .clk(clk), .rst_n(rst_n),
        .d({open_raw, otemp_raw, ovl_raw}), .q(raw_s)
    );
    assign ovl_s   = raw_s[NCH-1:0];
    assign otemp_s = raw_s[2*NCH-1:NCH];
    assign open_s  = raw_s[3*NCH-1:2*NCH];

    // Previous limp level for exit detection.
    always_ff @(posedge clk) begin
        if (!rst_n) limp_q <= 1'b0;
        else        limp_q <= limp;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        qc_chan #(.OVL_TICKS(OVL_TICKS), .OL_TICKS(OL_TICKS)) ch_i (
            .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .limp(limp),
            .limp_exit(limp_q & ~limp),
            .cmd(qc_pkg::cmd_e'(cmd[2*i +: 2])),
            .par(par_in[i]), .ovl_s(ovl_s[i]), .otemp_s(otemp_s[i]),
            .open_s(open_s[i]),
            .gate_on(gate_on[i]), .diag_en(diag_en[i]),
            .flt_ol(flt_ol[i]), .flt_d(flt_d[i])
        );
    end
endmodule

// File: rtl/quad_lsd_chan_ctrl_chk.sv
// Property checker for quad_lsd_chan_ctrl, attached by bind below.
// Assumes rst_n is synchronous active-low.
module quad_lsd_chan_ctrl_chk #(
    parameter int unsigned NCH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             limp,
    input logic [2*NCH-1:0] cmd,
    input logic [NCH-1:0]   gate_on,
    input logic [NCH-1:0]   diag_en,
    input logic [NCH-1:0]   flt_ol,
    input logic [NCH-1:0]   flt_d
);
    for (genvar i = 0; i < NCH; i++) begin : g_chk
        assert_lockout_R7: assert property (@(posedge clk) disable iff (!rst_n)
            flt_d[i] |-> !gate_on[i]);
        assert_diag_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
            diag_en[i] |-> !gate_on[i]);
        assert_ol_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flt_ol[i]) |-> $past(diag_en[i]));
        assert_en_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (!en && !limp) |=> (!flt_d[i] && !flt_ol[i] && !gate_on[i] && !diag_en[i]));
        assert_stby_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (en && !limp && cmd[2*i +: 2] == 2'b00) |=> (!flt_d[i] && !flt_ol[i]));
        assert_limp_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(limp) |=> (!flt_d[i] && !flt_ol[i]));
    end
endmodule

bind quad_lsd_chan_ctrl quad_lsd_chan_ctrl_chk #(.NCH(NCH)) chk_i (
    .clk(clk), .rst_n(rst_n), .en(en), .limp(limp), .cmd(cmd),
    .gate_on(gate_on), .diag_en(diag_en), .flt_ol(flt_ol), .flt_d(flt_d)
);

// File: tb/quad_lsd_chan_ctrl_tb_top.sv
// Bench: directed corner cases followed by seeded random command traffic.
module quad_lsd_chan_ctrl_tb_top;
    localparam int NCH = 4;
    localparam int OVL = 8;
    localparam int OLT = 20;

    logic clk = 0;
    logic rst_n, tick, en, limp;
    logic [2*NCH-1:0] cmd;
    logic [NCH-1:0] par_in, ovl_raw, otemp_raw, open_raw;
    logic [NCH-1:0] gate_on, diag_en, flt_ol, flt_d;
    logic [NCH-1:0] bq;
    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    quad_lsd_chan_ctrl #(.NCH(NCH), .OVL_TICKS(OVL), .OL_TICKS(OLT)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .limp(limp), .cmd(cmd),
        .par_in(par_in), .ovl_raw(ovl_raw), .otemp_raw(otemp_raw),
        .open_raw(open_raw), .gate_on(gate_on), .diag_en(diag_en),
        .flt_ol(flt_ol), .flt_d(flt_d)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic exp_gate(input logic [1:0] c, input logic p, input logic e);
        return e & ((c == 2'b10) | ((c == 2'b01) & p));
    endfunction

    function automatic logic exp_diag(input logic [1:0] c, input logic g, input logic e,
                                      input logic q);
        if (!e) return 1'b0;
        if (c == 2'b01) return ~g;
        if (c == 2'b11) return ~q;
        return 1'b0;
    endfunction

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5eed_0042);
        rst_n = 0; tick = 1; en = 1; limp = 0; cmd = 8'hFF;
        par_in = 0; ovl_raw = 0; otemp_raw = 0; open_raw = 0;
        wait_n(3);
        chk("R1 gate", gate_on, 0); chk("R1 diag", diag_en, 0);
        chk("R1 flt_ol", flt_ol, 0); chk("R1 flt_d", flt_d, 0);
        rst_n = 1;
        wait_n(2);
        chk("R4 quiet cmd11 diag", diag_en, 0);
        // ch0 and ch1 forced on, ch2 forced on, ch3 stays 11
        cmd = 8'b11_10_10_10;
        wait_n(2);
        chk("R2 forced on", gate_on, 4'b0111);
        // overload spike on ch1: filtered out
        ovl_raw[1] = 1; wait_n(3); ovl_raw[1] = 0; wait_n(12);
        chk("R5 spike flt_d", flt_d, 0);
        chk("R5 spike gate", gate_on, 4'b0111);
        // sustained overload on ch1
        ovl_raw[1] = 1; wait_n(20);
        chk("R5 long flt_d", flt_d, 4'b0010);
        chk("R5 long gate", gate_on, 4'b0101);
        ovl_raw[1] = 0; wait_n(5);
        chk("R7 stays off", gate_on[1], 0);
        // overtemperature on ch2, one-cycle pulse
        otemp_raw[2] = 1; wait_n(1); otemp_raw[2] = 0; wait_n(4);
        chk("R6 otemp flt_d", flt_d, 4'b0110);
        chk("R6 other channels", gate_on, 4'b0001);
        // standby clears ch1 only
        cmd = 8'b11_10_00_10; wait_n(2);
        chk("R9 stby clears own", flt_d, 4'b0100);
        cmd = 8'b11_10_10_10; wait_n(2);
        chk("R9 re-enable", gate_on, 4'b0011);
        // open load on ch3 while quiet: no flag
        open_raw[3] = 1; wait_n(30);
        chk("R4 quiet no OL", flt_ol, 0);
        cmd = 8'b00_10_10_10; wait_n(2);
        cmd = 8'b11_10_10_10; wait_n(2);
        chk("R3 cmd11 diag on", diag_en, 4'b1000);
        wait_n(30);
        chk("R8 OL set", flt_ol, 4'b1000);
        cmd = 8'b10_10_10_10; wait_n(2);
        chk("R8 still switches", gate_on, 4'b1011);
        chk("R8 flag held", flt_ol, 4'b1000);
        open_raw[3] = 0;
        // limp-home
        limp = 1; par_in = 4'b0101; cmd = 8'h00; wait_n(2);
        chk("R10 follows par", gate_on, 4'b0001);
        chk("R10 diag inverse", diag_en, 4'b1110);
        chk("R11 stby ignored", flt_d, 4'b0100);
        en = 0; wait_n(2);
        chk("R10 en ignored", gate_on, 4'b0001);
        chk("R11 en low ignored", flt_d, 4'b0100);
        ovl_raw[0] = 1; wait_n(20); ovl_raw[0] = 0; wait_n(3);
        chk("R11 limp latch", flt_d, 4'b0101);
        chk("R11 limp gate off", gate_on, 4'b0000);
        en = 1; wait_n(2); cmd = 8'hFF; limp = 0; wait_n(2);
        chk("R11 exit clears d", flt_d, 0);
        chk("R11 exit clears ol", flt_ol, 0);
        chk("R4 quiet after exit", diag_en, 0);
        // EN low clears everything
        cmd = 8'b11_11_10_10; otemp_raw[1] = 1; wait_n(4); otemp_raw[1] = 0; wait_n(3);
        chk("R6 setup flt_d", flt_d, 4'b0010);
        en = 0; wait_n(2);
        chk("R12 gate", gate_on, 0); chk("R12 diag", diag_en, 0);
        chk("R12 flt_d", flt_d, 0);
        bq = '1;
        // random command traffic
        for (int it = 0; it < 300; it++) begin
            logic [NCH-1:0] eg, ed;
            cmd    = 8'($urandom);
            par_in = 4'($urandom);
            en     = (($urandom % 10) != 0);
            if (!en) bq = '1;
            else for (int c = 0; c < NCH; c++) if (cmd[2*c +: 2] != 2'b11) bq[c] = 1'b0;
            for (int c = 0; c < NCH; c++) begin
                eg[c] = exp_gate(cmd[2*c +: 2], par_in[c], en);
                ed[c] = exp_diag(cmd[2*c +: 2], eg[c], en, bq[c]);
            end
            wait_n(2);
            chk("R2 random gate", gate_on, eg);
            chk("R3 random diag", diag_en, ed);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule